// File: doc/BRIEF.md
# SMBus Host Command and Status Front End

This block is the register-side half of an SMBus host controller. Software reaches it over a byte-wide register port. Through that port it loads the target address, the command byte and the data bytes, picks a transaction type, and launches the transaction by writing the control byte with its start bit set. A separate bus engine does the wire-level work. It receives a one-cycle launch pulse, a kill line and the programmed fields. It reports back with completion, no-acknowledge, lost-arbitration and byte-done pulses, and with received data.

A small state machine tracks host busy. Its states are `HS_IDLE`, `HS_LAUNCH`, `HS_ACTIVE` and `HS_ABORT`, and it has these transitions:
- `HS_IDLE`→`HS_LAUNCH` on an accepted start write.
- `HS_LAUNCH`→`HS_ACTIVE` unconditionally.
- `HS_ACTIVE`→`HS_IDLE` on done, no-acknowledge or lost arbitration.
- `HS_ACTIVE`→`HS_ABORT` when the kill bit is held.
- `HS_ABORT`→`HS_IDLE` once software clears kill.

The status byte collects the outcome flags. Software clears each of them by writing 1 to its position.

Top module: `smbus_host_front`

## Requirements
- R1: Register offsets: command 3, address 4, data-low 5, data-high 6, block byte 7, check byte 8. Each of these reads back the full byte last written. Auxiliary control at 13 keeps bits[1:0] only; bit 0 drives `eng_hw_pec` and bit 1 drives `eng_buf32`. Offset 12 and all unlisted offsets read 0, and writes to them have no effect.
- R2: The control byte at offset 2 uses these fields: bits[4:2] transaction type (0 quick, 1 byte, 2 byte-data, 3 word, 4 process call, 5 block, 6 I2C block), bit 5 last byte, bit 7 check-byte enable, bit 1 kill. It reads back with bits 6 and 0 as zero.
- R3: A control write with bit 6 = 1 and bit 1 = 0 in `HS_IDLE` gives `eng_start` high for exactly the cycle after the write edge. Busy (status bit 0 and `host_busy`) is high from that cycle on.
- R4: While busy, a start write launches nothing. Control writes outside `HS_IDLE` change only the kill bit.
- R5: A done pulse in `HS_ACTIVE` sets the complete flag (status bit 1) and drops busy on the same edge.
- R6: No-acknowledge sets status bit 2 and lost arbitration sets status bit 3, each in place of complete, and busy drops. When they coincide, lost arbitration wins over no-acknowledge, which wins over done.
- R7: With kill held in `HS_ACTIVE`, the next edge drops busy, sets the failed flag (bit 4) and raises `eng_kill`. `eng_kill` stays high, and start writes are ignored, until kill reads 0. One cycle later the block is idle.
- R8: Writing 1 to status bits 7, 4, 3, 2 or 1 clears that flag, and writing 0 leaves it. A flag set and cleared on the same edge stays set.
- R9: Byte-done in `HS_ACTIVE` sets status bit 7 without ending the transaction.
- R10: `eng_target` is address bits[7:1] and `eng_read` is address bit 0.
- R11: A receive-valid pulse loads `eng_rx0` into data-low and `eng_rx1` into data-high, overriding a bus write in the same cycle.
- R12: Engine done, no-acknowledge, lost-arbitration and byte-done pulses outside `HS_ACTIVE` change no flag and no state.
- R13: After reset every register and flag reads 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | AW | Write offset |
| reg_wr_data | input | DW | Write byte |
| reg_rd_addr | input | AW | Read offset |
| reg_rd_data | output | DW | Read byte (combinational) |
| eng_start | output | 1 | Launch pulse to the engine |
| eng_kill | output | 1 | Abort request to the engine |
| eng_kind | output | 3 | Transaction type |
| eng_last | output | 1 | Last-byte marker |
| eng_pec_en | output | 1 | Check-byte enable from control |
| eng_target | output | 7 | Target address |
| eng_read | output | 1 | Direction, 1 = read |
| eng_cmd | output | DW | Command byte |
| eng_tx0 | output | DW | Data-low byte |
| eng_tx1 | output | DW | Data-high byte |
| eng_blk | output | DW | Block data byte |
| eng_pec_byte | output | DW | Check byte register |
| eng_hw_pec | output | 1 | Auxiliary hardware check enable |
| eng_buf32 | output | 1 | Auxiliary 32-byte buffer enable |
| host_busy | output | 1 | Transaction in progress |
| eng_done | input | 1 | Transaction finished cleanly |
| eng_nack | input | 1 | Device did not acknowledge |
| eng_lost | input | 1 | Arbitration lost |
| eng_byte_done | input | 1 | One byte moved |
| eng_rx_valid | input | 1 | Received bytes valid |
| eng_rx0 | input | DW | Received low byte |
| eng_rx1 | input | DW | Received high byte |

## Verification
The bench targets several corner cases:
- A second start while busy: a faulty design would relaunch or overwrite the transaction type in flight.
- Kill held across `HS_ACTIVE` and cleared by a later start write: a faulty design would keep busy high, skip the failed flag or launch from the abort state.
- Coincident error pulses and a clear that lands on the same edge as a set: these expose wrong priority or a lost flag.
- Engine pulses while idle, and receive data overriding a bus write: these catch spurious flags and the wrong winner on the data registers.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int OFS_STAT = 0;
    localparam int OFS_CTRL = 2;
    localparam int OFS_CMD  = 3;
    localparam int OFS_ADDR = 4;
    localparam int OFS_D0   = 5;
    localparam int OFS_D1   = 6;
    localparam int OFS_BLK  = 7;
    localparam int OFS_PEC  = 8;
    localparam int OFS_AUXS = 12;
    localparam int OFS_AUXC = 13;

    localparam int CTL_KILL  = 1;
    localparam int CTL_KLO   = 2;
    localparam int CTL_KHI   = 4;
    localparam int CTL_LAST  = 5;
    localparam int CTL_START = 6;
    localparam int CTL_PEC   = 7;

    localparam int ST_BUSY  = 0;
    localparam int ST_CPL   = 1;
    localparam int ST_DEV   = 2;
    localparam int ST_BUS   = 3;
    localparam int ST_FAIL  = 4;
    localparam int ST_BDONE = 7;

    localparam int AUX_W = 2;

    typedef enum logic [2:0] {
        XK_QUICK, XK_BYTE, XK_BYTE_DATA, XK_WORD,
        XK_PROC, XK_BLOCK, XK_I2C_BLOCK, XK_RSVD
    } xact_kind_e;

    typedef enum logic [1:0] {
        HS_IDLE, HS_LAUNCH, HS_ACTIVE, HS_ABORT
    } host_state_e;

    typedef struct packed {
        logic byte_done;
        logic failed;
        logic bus_err;
        logic dev_err;
        logic complete;
    } flag_set_t;
endpackage

// File: rtl/smbh_status.sv
module smbh_status
    import smbh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_set_t set_i,
    input  flag_set_t clr_i,
    output flag_set_t flags_o
);
    timeunit 1ns;
    timeprecision 1ps;

    flag_set_t flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
        end
    end

    assign flags_o = flags_q;

    property p_clear_complete;
        @(posedge clk) disable iff (!rst_n)
        (clr_i.complete && !set_i.complete) |=> !flags_o.complete;
    endproperty
    assert_w1c_clears_R8: assert property (p_clear_complete);

    property p_set_wins;
        @(posedge clk) disable iff (!rst_n)
        (set_i.failed) |=> flags_o.failed;
    endproperty
    assert_set_over_clear_R8: assert property (p_set_wins);

    property p_zero_keeps;
        @(posedge clk) disable iff (!rst_n)
        (!clr_i.dev_err && flags_o.dev_err) |=> flags_o.dev_err;
    endproperty
    assert_zero_write_keeps_R8: assert property (p_zero_keeps);
endmodule

// File: rtl/smbh_fsm.sv
module smbh_fsm
    import smbh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_req_i,
    input  logic      kill_i,
    input  logic      done_i,
    input  logic      nack_i,
    input  logic      lost_i,
    input  logic      byte_done_i,
    output logic      busy_o,
    output logic      start_o,
    output logic      kill_o,
    output logic      ctrl_open_o,
    output flag_set_t set_o
);
    timeunit 1ns;
    timeprecision 1ps;

    host_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:   if (start_req_i) state_d = HS_LAUNCH;
            HS_LAUNCH: state_d = HS_ACTIVE;
            HS_ACTIVE: begin
                if (kill_i)                          state_d = HS_ABORT;
                else if (lost_i || nack_i || done_i) state_d = HS_IDLE;
            end
            HS_ABORT:  if (!kill_i) state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        busy_o      = 1'b0;
        start_o     = 1'b0;
        kill_o      = 1'b0;
        ctrl_open_o = 1'b0;
        set_o       = '0;
        unique case (state_q)
            HS_IDLE:   ctrl_open_o = 1'b1;
            HS_LAUNCH: begin
                busy_o  = 1'b1;
                start_o = 1'b1;
            end
            HS_ACTIVE: begin
                busy_o            = 1'b1;
                set_o.byte_done   = byte_done_i;
                set_o.failed      = kill_i;
                set_o.bus_err     = !kill_i && lost_i;
                set_o.dev_err     = !kill_i && !lost_i && nack_i;
                set_o.complete    = !kill_i && !lost_i && !nack_i && done_i;
            end
            HS_ABORT:  kill_o = 1'b1;
        endcase
    end

    property p_launch;
        @(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && start_req_i) |=> (start_o && busy_o);
    endproperty
    assert_launch_R3: assert property (p_launch);

    property p_pulse;
        @(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o;
    endproperty
    assert_start_one_cycle_R3: assert property (p_pulse);

    property p_no_relaunch;
        @(posedge clk) disable iff (!rst_n)
        (busy_o && start_req_i) |=> !start_o;
    endproperty
    assert_busy_start_ignored_R4: assert property (p_no_relaunch);

    property p_done;
        @(posedge clk) disable iff (!rst_n)
        (state_q == HS_ACTIVE && done_i && !kill_i) |=> !busy_o;
    endproperty
    assert_done_drops_busy_R5: assert property (p_done);

    property p_err;
        @(posedge clk) disable iff (!rst_n)
        (state_q == HS_ACTIVE && !kill_i && (lost_i || nack_i)) |=> (!busy_o && !kill_o);
    endproperty
    assert_error_ends_R6: assert property (p_err);

    property p_kill;
        @(posedge clk) disable iff (!rst_n)
        (state_q == HS_ACTIVE && kill_i) |=> (!busy_o && kill_o);
    endproperty
    assert_kill_aborts_R7: assert property (p_kill);

    property p_idle_hold;
        @(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && !start_req_i) |=> (state_q == HS_IDLE);
    endproperty
    assert_idle_events_ignored_R12: assert property (p_idle_hold);
endmodule

// File: rtl/smbh_regfile.sv
module smbh_regfile
    import smbh_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [DW-1:0]    rd_data_o,
    input  logic             ctrl_open_i,
    input  logic             busy_i,
    input  flag_set_t        flags_i,
    input  logic             rx_valid_i,
    input  logic [DW-1:0]    rx0_i,
    input  logic [DW-1:0]    rx1_i,
    output logic             start_req_o,
    output flag_set_t        clr_o,
    output logic             kill_o,
    output xact_kind_e       kind_o,
    output logic             last_o,
    output logic             pec_en_o,
    output logic [DW-1:0]    cmd_o,
    output logic [DW-1:0]    addr_o,
    output logic [DW-1:0]    d0_o,
    output logic [DW-1:0]    d1_o,
    output logic [DW-1:0]    blk_o,
    output logic [DW-1:0]    pec_o,
    output logic [AUX_W-1:0] aux_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);
    localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_CMD  = AW'(OFS_CMD);
    localparam logic [AW-1:0] A_ADDR = AW'(OFS_ADDR);
    localparam logic [AW-1:0] A_D0   = AW'(OFS_D0);
    localparam logic [AW-1:0] A_D1   = AW'(OFS_D1);
    localparam logic [AW-1:0] A_BLK  = AW'(OFS_BLK);
    localparam logic [AW-1:0] A_PEC  = AW'(OFS_PEC);
    localparam logic [AW-1:0] A_AUXC = AW'(OFS_AUXC);

    logic              kill_q, last_q, pecen_q;
    xact_kind_e        kind_q;
    logic [DW-1:0]     cmd_q, addr_q, d0_q, d1_q, blk_q, pec_q;
    logic [AUX_W-1:0]  aux_q;

    wire ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
    wire stat_wr = wr_en_i && (wr_addr_i == A_STAT);

    assign start_req_o = ctrl_wr && wr_data_i[CTL_START] && !wr_data_i[CTL_KILL];

    always_comb begin
        clr_o = '0;
        if (stat_wr) begin
            clr_o.byte_done = wr_data_i[ST_BDONE];
            clr_o.failed    = wr_data_i[ST_FAIL];
            clr_o.bus_err   = wr_data_i[ST_BUS];
            clr_o.dev_err   = wr_data_i[ST_DEV];
            clr_o.complete  = wr_data_i[ST_CPL];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kill_q  <= 1'b0;
            last_q  <= 1'b0;
            pecen_q <= 1'b0;
            kind_q  <= XK_QUICK;
            cmd_q   <= '0;
            addr_q  <= '0;
            d0_q    <= '0;
            d1_q    <= '0;
            blk_q   <= '0;
            pec_q   <= '0;
            aux_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                kill_q <= wr_data_i[CTL_KILL];
                if (ctrl_open_i) begin
                    kind_q  <= xact_kind_e'(wr_data_i[CTL_KHI:CTL_KLO]);
                    last_q  <= wr_data_i[CTL_LAST];
                    pecen_q <= wr_data_i[CTL_PEC];
                end
            end
            if (wr_en_i) begin
                if (wr_addr_i == A_CMD)  cmd_q  <= wr_data_i;
                if (wr_addr_i == A_ADDR) addr_q <= wr_data_i;
                if (wr_addr_i == A_D0)   d0_q   <= wr_data_i;
                if (wr_addr_i == A_D1)   d1_q   <= wr_data_i;
                if (wr_addr_i == A_BLK)  blk_q  <= wr_data_i;
                if (wr_addr_i == A_PEC)  pec_q  <= wr_data_i;
                if (wr_addr_i == A_AUXC) aux_q  <= wr_data_i[AUX_W-1:0];
            end
            if (rx_valid_i) begin
                d0_q <= rx0_i;
                d1_q <= rx1_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_STAT: begin
                rd_data_o[ST_BDONE] = flags_i.byte_done;
                rd_data_o[ST_FAIL]  = flags_i.failed;
                rd_data_o[ST_BUS]   = flags_i.bus_err;
                rd_data_o[ST_DEV]   = flags_i.dev_err;
                rd_data_o[ST_CPL]   = flags_i.complete;
                rd_data_o[ST_BUSY]  = busy_i;
            end
            A_CTRL: begin
                rd_data_o[CTL_PEC]           = pecen_q;
                rd_data_o[CTL_LAST]          = last_q;
                rd_data_o[CTL_KHI:CTL_KLO]   = kind_q;
                rd_data_o[CTL_KILL]          = kill_q;
            end
            A_CMD:  rd_data_o = cmd_q;
            A_ADDR: rd_data_o = addr_q;
            A_D0:   rd_data_o = d0_q;
            A_D1:   rd_data_o = d1_q;
            A_BLK:  rd_data_o = blk_q;
            A_PEC:  rd_data_o = pec_q;
            A_AUXC: rd_data_o[AUX_W-1:0] = aux_q;
            default: rd_data_o = '0;
        endcase
    end

    assign kill_o   = kill_q;
    assign kind_o   = kind_q;
    assign last_o   = last_q;
    assign pec_en_o = pecen_q;
    assign cmd_o    = cmd_q;
    assign addr_o   = addr_q;
    assign d0_o     = d0_q;
    assign d1_o     = d1_q;
    assign blk_o    = blk_q;
    assign pec_o    = pec_q;
    assign aux_o    = aux_q;

    property p_freeze;
        @(posedge clk) disable iff (!rst_n)
        (!ctrl_open_i) |=> ($stable(kind_q) && $stable(last_q) && $stable(pecen_q));
    endproperty
    assert_ctrl_frozen_busy_R4: assert property (p_freeze);

    property p_rx_wins;
        @(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> (d0_q == $past(rx0_i) && d1_q == $past(rx1_i));
    endproperty
    assert_rx_loads_data_R11: assert property (p_rx_wins);
endmodule

// File: rtl/smbus_host_front.sv
module smbus_host_front
    import smbh_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_wr_addr,
    input  logic [DW-1:0] reg_wr_data,
    input  logic [AW-1:0] reg_rd_addr,
    output logic [DW-1:0] reg_rd_data,
    output logic          eng_start,
    output logic          eng_kill,
    output logic [2:0]    eng_kind,
    output logic          eng_last,
    output logic          eng_pec_en,
    output logic [6:0]    eng_target,
    output logic          eng_read,
    output logic [DW-1:0] eng_cmd,
    output logic [DW-1:0] eng_tx0,
    output logic [DW-1:0] eng_tx1,
    output logic [DW-1:0] eng_blk,
    output logic [DW-1:0] eng_pec_byte,
    output logic          eng_hw_pec,
    output logic          eng_buf32,
    output logic          host_busy,
    input  logic          eng_done,
    input  logic          eng_nack,
    input  logic          eng_lost,
    input  logic          eng_byte_done,
    input  logic          eng_rx_valid,
    input  logic [DW-1:0] eng_rx0,
    input  logic [DW-1:0] eng_rx1
);
    timeunit 1ns;
    timeprecision 1ps;

    logic             start_req, kill_q, ctrl_open, busy;
    flag_set_t        set_v, clr_v, flags_v;
    xact_kind_e       kind_v;
    logic [DW-1:0]    addr_v;
    logic [AUX_W-1:0] aux_v;

    smbh_regfile #(.AW(AW), .DW(DW)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (reg_wr_en),
        .wr_addr_i   (reg_wr_addr),
        .wr_data_i   (reg_wr_data),
        .rd_addr_i   (reg_rd_addr),
        .rd_data_o   (reg_rd_data),
        .ctrl_open_i (ctrl_open),
        .busy_i      (busy),
        .flags_i     (flags_v),
        .rx_valid_i  (eng_rx_valid),
        .rx0_i       (eng_rx0),
        .rx1_i       (eng_rx1),
        .start_req_o (start_req),
        .clr_o       (clr_v),
        .kill_o      (kill_q),
        .kind_o      (kind_v),
        .last_o      (eng_last),
        .pec_en_o    (eng_pec_en),
        .cmd_o       (eng_cmd),
        .addr_o      (addr_v),
        .d0_o        (eng_tx0),
        .d1_o        (eng_tx1),
        .blk_o       (eng_blk),
        .pec_o       (eng_pec_byte),
        .aux_o       (aux_v)
    );

    smbh_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req),
        .kill_i      (kill_q),
        .done_i      (eng_done),
        .nack_i      (eng_nack),
        .lost_i      (eng_lost),
        .byte_done_i (eng_byte_done),
        .busy_o      (busy),
        .start_o     (eng_start),
        .kill_o      (eng_kill),
        .ctrl_open_o (ctrl_open),
        .set_o       (set_v)
    );

    smbh_status stat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .flags_o (flags_v)
    );

    assign eng_kind   = kind_v;
    assign eng_target = addr_v[7:1];
    assign eng_read   = addr_v[0];
    assign eng_hw_pec = aux_v[0];
    assign eng_buf32  = aux_v[1];
    assign host_busy  = busy;

    property p_kill_not_busy;
        @(posedge clk) disable iff (!rst_n)
        eng_kill |-> !host_busy;
    endproperty
    assert_kill_excludes_busy_R7: assert property (p_kill_not_busy);
endmodule

// File: tb/smbus_host_front_tb_top.sv
module smbus_host_front_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wa = '0;
    logic [7:0] wd = '0;
    logic [3:0] ra = '0;
    logic [7:0] rdata;
    logic       e_start, e_kill, e_last, e_pecen, e_read, e_hwpec, e_buf32, busy;
    logic [2:0] e_kind;
    logic [6:0] e_tgt;
    logic [7:0] e_cmd, e_tx0, e_tx1, e_blk, e_pecb;
    logic       ev_done = 0, ev_nack = 0, ev_lost = 0, ev_bd = 0, ev_rxv = 0;
    logic [7:0] ev_rx0 = '0, ev_rx1 = '0;

    int checks = 0;
    int errs = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smbus_host_front #(.AW(4), .DW(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(wr_en), .reg_wr_addr(wa), .reg_wr_data(wd),
        .reg_rd_addr(ra), .reg_rd_data(rdata),
        .eng_start(e_start), .eng_kill(e_kill), .eng_kind(e_kind),
        .eng_last(e_last), .eng_pec_en(e_pecen), .eng_target(e_tgt),
        .eng_read(e_read), .eng_cmd(e_cmd), .eng_tx0(e_tx0), .eng_tx1(e_tx1),
        .eng_blk(e_blk), .eng_pec_byte(e_pecb), .eng_hw_pec(e_hwpec),
        .eng_buf32(e_buf32), .host_busy(busy),
        .eng_done(ev_done), .eng_nack(ev_nack), .eng_lost(ev_lost),
        .eng_byte_done(ev_bd), .eng_rx_valid(ev_rxv),
        .eng_rx0(ev_rx0), .eng_rx1(ev_rx1)
    );

    // ---------------- behavioural reference model ----------------
    int         m_st;          // 0 idle, 1 launch, 2 active, 3 abort
    logic [7:0] m_flags;
    logic [7:0] m_reg [16];
    logic [2:0] m_kind;
    logic       m_last, m_pecen, m_kill;
    int         n_st;
    logic [7:0] n_set, n_clr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_flags = 0; m_kind = 0; m_last = 0; m_pecen = 0; m_kill = 0;
            for (int i = 0; i < 16; i++) m_reg[i] = 0;
        end else begin
            n_st = m_st; n_set = 0; n_clr = 0;
            if (m_st == 0) begin
                if (wr_en && wa == 2 && wd[6] && !wd[1]) n_st = 1;
            end else if (m_st == 1) begin
                n_st = 2;
            end else if (m_st == 2) begin
                if (ev_bd) n_set = n_set | 8'h80;
                if (m_kill)       begin n_set = n_set | 8'h10; n_st = 3; end
                else if (ev_lost) begin n_set = n_set | 8'h08; n_st = 0; end
                else if (ev_nack) begin n_set = n_set | 8'h04; n_st = 0; end
                else if (ev_done) begin n_set = n_set | 8'h02; n_st = 0; end
            end else begin
                if (!m_kill) n_st = 0;
            end
            if (wr_en && wa == 0) n_clr = wd & 8'h9E;
            m_flags = (m_flags & ~n_clr) | n_set;
            if (wr_en) begin
                if (wa == 2) begin
                    if (m_st == 0) begin
                        m_kind = wd[4:2]; m_last = wd[5]; m_pecen = wd[7];
                    end
                    m_kill = wd[1];
                end else if (wa >= 3 && wa <= 8) begin
                    m_reg[wa] = wd;
                end else if (wa == 13) begin
                    m_reg[13] = {6'b0, wd[1:0]};
                end
            end
            if (ev_rxv) begin m_reg[5] = ev_rx0; m_reg[6] = ev_rx1; end
            m_st = n_st;
        end
    end

    function automatic logic [7:0] m_read(input logic [3:0] a);
        logic mbusy;
        mbusy = (m_st == 1 || m_st == 2);
        if (a == 0) return {m_flags[7:1], mbusy};
        if (a == 2) return {m_pecen, 1'b0, m_last, m_kind, m_kill, 1'b0};
        if ((a >= 3 && a <= 8) || a == 13) return m_reg[a];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 readback", rdata, m_read(ra));
            chk("R3 busy", {7'b0, busy}, {7'b0, (m_st == 1 || m_st == 2)});
            chk("R3 start pulse", {7'b0, e_start}, {7'b0, (m_st == 1)});
            chk("R7 kill out", {7'b0, e_kill}, {7'b0, (m_st == 3)});
            chk("R2 kind", {5'b0, e_kind}, {5'b0, m_kind});
            chk("R10 target", {e_tgt, e_read}, m_reg[4]);
            chk("R11 data0", e_tx0, m_reg[5]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            errs++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wa = a; wd = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        ra = a; #0.5; d = rdata;
    endtask

    task automatic ev(input logic dn, input logic nk, input logic ls, input logic bd);
        @(posedge clk); #1;
        ev_done = dn; ev_nack = nk; ev_lost = ls; ev_bd = bd;
        @(posedge clk); #1;
        ev_done = 0; ev_nack = 0; ev_lost = 0; ev_bd = 0;
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        rd(0, v); chk("R13 status after reset", v, 8'h00);
        rd(2, v); chk("R13 control after reset", v, 8'h00);
        chk("R13 busy after reset", {7'b0, busy}, 8'h00);

        wr(3, 8'hA5); rd(3, v); chk("R1 command", v, 8'hA5);
        wr(4, 8'h5B); rd(4, v); chk("R1 address", v, 8'h5B);
        chk("R10 target bits", {1'b0, e_tgt}, 8'h2D);
        chk("R10 direction bit", {7'b0, e_read}, 8'h01);
        wr(5, 8'h11); rd(5, v); chk("R1 data low", v, 8'h11);
        wr(6, 8'h22); rd(6, v); chk("R1 data high", v, 8'h22);
        wr(7, 8'h33); rd(7, v); chk("R1 block byte", v, 8'h33);
        wr(8, 8'h44); rd(8, v); chk("R1 check byte", v, 8'h44);
        wr(13, 8'hFF); rd(13, v); chk("R1 aux control", v, 8'h03);
        chk("R1 aux outputs", {6'b0, e_buf32, e_hwpec}, 8'h03);
        wr(9, 8'h77); rd(9, v); chk("R1 unmapped offset", v, 8'h00);
        wr(12, 8'hFF); rd(12, v); chk("R1 aux status", v, 8'h00);

        wr(2, 8'hAD); rd(2, v); chk("R2 control fields", v, 8'hAC);
        chk("R2 field outputs", {3'b0, e_pecen, e_last, e_kind}, 8'h1B);

        wr(2, 8'h4C);
        chk("R3 start pulse", {7'b0, e_start}, 8'h01);
        rd(0, v); chk("R3 busy in status", v, 8'h01);
        rd(2, v); chk("R2 start reads zero", v, 8'h0C);
        tick();
        chk("R3 start ends", {7'b0, e_start}, 8'h00);
        chk("R3 busy holds", {7'b0, busy}, 8'h01);

        wr(2, 8'h54);
        rd(2, v); chk("R4 type frozen", v, 8'h0C);
        chk("R4 no relaunch", {7'b0, e_start}, 8'h00);

        @(posedge clk); #1;
        ev_rxv = 1; ev_rx0 = 8'hC3; ev_rx1 = 8'h3C; ev_done = 1;
        wr_en = 1; wa = 5; wd = 8'h99;
        @(posedge clk); #1;
        ev_rxv = 0; ev_done = 0; wr_en = 0;
        rd(5, v); chk("R11 low byte", v, 8'hC3);
        rd(6, v); chk("R11 high byte", v, 8'h3C);
        rd(0, v); chk("R5 complete and idle", v, 8'h02);

        wr(0, 8'h00); rd(0, v); chk("R8 zero write keeps", v, 8'h02);
        wr(0, 8'hFD); rd(0, v); chk("R8 other bits keep", v, 8'h02);
        wr(0, 8'h02); rd(0, v); chk("R8 one clears", v, 8'h00);

        wr(2, 8'h40); ev(0, 1, 0, 0);
        rd(0, v); chk("R6 no ack flag", v, 8'h04);
        wr(0, 8'h04);
        wr(2, 8'h40); ev(1, 1, 1, 0);
        rd(0, v); chk("R6 lost wins", v, 8'h08);
        wr(0, 8'h08);

        wr(2, 8'h40); ev(0, 0, 0, 1);
        rd(0, v); chk("R9 byte done keeps busy", v, 8'h81);
        wr(0, 8'h80); rd(0, v); chk("R8 byte done cleared", v, 8'h01);

        wr(2, 8'h02); tick();
        chk("R7 busy dropped", {7'b0, busy}, 8'h00);
        chk("R7 kill raised", {7'b0, e_kill}, 8'h01);
        rd(0, v); chk("R7 failed flag", v, 8'h10);
        ev(1, 0, 0, 0);
        rd(0, v); chk("R12 done in abort ignored", v, 8'h10);
        wr(2, 8'h40);
        chk("R7 start ignored in abort", {7'b0, e_start}, 8'h00);
        tick();
        chk("R7 kill released", {7'b0, e_kill}, 8'h00);
        chk("R7 still idle", {7'b0, busy}, 8'h00);

        ev(1, 1, 1, 1);
        rd(0, v); chk("R12 idle events ignored", v, 8'h10);
        wr(0, 8'h10); rd(0, v); chk("R8 failed cleared", v, 8'h00);

        wr(2, 8'h40);
        @(posedge clk); #1;
        ev_done = 1; wr_en = 1; wa = 0; wd = 8'h02;
        @(posedge clk); #1;
        ev_done = 0; wr_en = 0;
        rd(0, v); chk("R8 set wins over clear", v, 8'h02);
        wr(0, 8'hFF);

        for (int k = 0; k < 600; k++) begin
            @(posedge clk); #1;
            wr_en = ($urandom % 3) == 0;
            case ($urandom % 5)
                0, 1: wa = 2;
                2:    wa = 0;
                default: wa = 4'($urandom);
            endcase
            wd = 8'($urandom);
            ra = 4'($urandom);
            ev_done = ($urandom % 6) == 0;
            ev_nack = ($urandom % 9) == 0;
            ev_lost = ($urandom % 11) == 0;
            ev_bd   = ($urandom % 5) == 0;
            ev_rxv  = ($urandom % 7) == 0;
            ev_rx0  = 8'($urandom);
            ev_rx1  = 8'($urandom);
        end
        @(posedge clk); #1;
        wr_en = 0; ev_done = 0; ev_nack = 0; ev_lost = 0; ev_bd = 0; ev_rxv = 0;
        repeat (4) @(posedge clk);
        #1 finish_run();
    end
endmodule